// File: doc/BRIEF.md
# I2C Master Clock and Pad-Drive Bit Sequencer

This block produces the SCL waveform and the pad drive controls for one bit at a time on an I2C master. A byte engine above it asks for one of three bit types: send a bit, receive a data bit, or receive an acknowledge. The sequencer then drives SCL low for one half-period and releases or drives it high for the second half-period. It places the outgoing SDA level while SCL is low and samples SDA in the middle of the high phase. At the end it returns a one-cycle completion pulse that carries the sampled value.

An 8-bit control byte sets the rest of the behaviour. It picks one of four SCL/SDA pad pairs, chooses standard or fast timing, enables push-pull drive, and holds a 4-bit rate index. In push-pull mode the master drives both levels and halves the half-period, which doubles the rate. Push-pull applies only to send bits and only below the two top rate indices. Bits that come from the slave always run open-drain at the un-doubled rate. A separate stretch input adds wait cycles to every high phase, to cover slow rising edges or filter delay.

Top module: `i2c_scl_phy`

## Requirements
- R1: After reset the control byte is 00h, `idle` is 1, `done` is 0, and every output-enable and drive-high output is 0.
- R2: Control bits [7:6] select the pad pair: 00 selects pair 0, 01 pair 1, 10 pair 2 and 11 pair 3. All four drive outputs of every other pair stay 0.
- R3: In open-drain operation a bit holds SCL low for H clock cycles and then high for H+S cycles. S is the `stretch` input. H is (bit5 ? FAST_UNIT : STD_UNIT) * (16 - index), where index is control bits [3:0], and H is never less than 2.
- R4: When control bit 4 (push-pull) is 1, the index is below 14 and the request is a send, the low and high phases each last max(2, floor(H/2)) cycles, with S added to the high phase. During that bit `scl_oe` stays 1 and `scl_hi` follows the SCL level. SDA has `sda_oe` = 1 and `sda_hi` equal to the bit.
- R5: At index 1110 or 1111 the push-pull bit is ignored, and a send bit runs open-drain with the full H.
- R6: A receive request (`req_kind` 01 for data, 10 for acknowledge) always runs open-drain with the full H, with SDA released (`sda_oe` = 0, `sda_hi` = 0), even when push-pull is enabled.
- R7: In open-drain operation `*_oe` = 1 means pull the line low and `*_oe` = 0 means release it. The `*_hi` outputs stay 0.
- R8: The logical SDA level placed on the selected pair changes only while SCL is low.
- R9: Each unit of `stretch` adds exactly one cycle to the high phase and none to the low phase.
- R10: A request is accepted only while `idle` is 1. A request that arrives during a bit does not change that bit's timing or drive, and it starts no further bit.
- R11: `done` pulses for one cycle, in the first cycle after the last high-phase cycle. `done_bit` equals the selected pair's `sda_in` as sampled at high-phase cycle floor((H'+S)/2), counting from 0, where H' is the half-period in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_data | input | 8 | Control byte: [7:6] pair, [5] fast, [4] push-pull, [3:0] rate index |
| stretch | input | STW | Extra high-phase wait cycles |
| req_valid | input | 1 | Bit request strobe |
| req_kind | input | 2 | 00 send, 01 receive data, 10 receive acknowledge |
| req_bit | input | 1 | Level to send |
| idle | output | 1 | Sequencer can accept a request |
| done | output | 1 | One-cycle end-of-bit pulse |
| done_bit | output | 1 | SDA value sampled in the high phase |
| scl_oe | output | NPAIR | SCL output enable per pair |
| scl_hi | output | NPAIR | SCL drive-high per pair |
| sda_oe | output | NPAIR | SDA output enable per pair |
| sda_hi | output | NPAIR | SDA drive-high per pair |
| sda_in | input | NPAIR | SDA pad level per pair |

## Verification
Two things can coincide with a busy bit: a new request strobe, and the high-phase sample of SDA. The bench raises `req_valid` in the third low cycle of a running bit. It then checks that the low and high counts still match the table, and that SCL stays high with `idle` set for several cycles after `done`. The bench also keeps `sda_in` at the inverse value on every high cycle except the predicted sample cycle, so `done_bit` can only be right if the sample lands on exactly that cycle.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_LOW = 2'd1, PH_HIGH = 2'd2} phase_e;

  localparam logic [1:0] K_SEND  = 2'd0;
  localparam logic [1:0] K_RDATA = 2'd1;
  localparam logic [1:0] K_RACK  = 2'd2;

  // control byte layout; positions are decoded by the sequencer
  typedef struct packed {
    logic [1:0] bus;
    logic       fast;
    logic       pp;
    logic [3:0] idx;
  } ctl_t;

  // open-drain half period in system clocks, floor of 2
  function automatic int unsigned od_half(input logic [3:0] idx, input logic fast,
                                          input int unsigned su, input int unsigned fu);
    int unsigned v;
    v = (fast ? fu : su) * (32'd16 - {28'd0, idx});
    if (v < 32'd2) v = 32'd2;
    return v;
  endfunction

  // push-pull half period: half of the open-drain one, floor of 2
  function automatic int unsigned pp_half(input int unsigned h);
    int unsigned v;
    v = h >> 1;
    if (v < 32'd2) v = 32'd2;
    return v;
  endfunction

  // the two fastest indices forbid active high drive
  function automatic logic pp_allowed(input logic [3:0] idx);
    return idx < 4'd14;
  endfunction

endpackage

// File: rtl/sclgen_ctl.sv
module sclgen_ctl
  import sclgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output ctl_t       ctl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (wr) ctl <= ctl_t'(wdata);
  end

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import sclgen_pkg::*;
#(
  parameter int unsigned STD_UNIT  = 4,
  parameter int unsigned FAST_UNIT = 2,
  parameter int unsigned STW       = 4,
  parameter int unsigned BUS_W     = 2,
  localparam int unsigned CW = $clog2(STD_UNIT * 16 + FAST_UNIT * 16 + (1 << STW)) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic [STW-1:0]   stretch,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_bit,
  input  logic             sda_rx,
  output logic             idle,
  output logic             done,
  output logic             done_bit,
  output logic             scl_lvl,
  output logic             sda_drv,
  output logic             sda_lvl,
  output logic             pp_act,
  output logic [BUS_W-1:0] bus_q
);

  phase_e         st;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  hc_q;
  logic [STW-1:0] str_q;
  logic [1:0]     kind_q;
  logic           bit_q;
  logic           pp_q;
  logic           done_q;
  logic           samp_q;

  // named internal events
  logic           accept;
  logic           use_pp;
  logic [CW-1:0]  hc_n;
  logic [CW-1:0]  hlen;
  logic           low_last;
  logic           high_last;
  logic           sample_pt;
  int unsigned    h_od;

  assign accept = (st == PH_IDLE) && req_valid;

  always_comb begin
    h_od   = od_half(ctl.idx, ctl.fast, STD_UNIT, FAST_UNIT);
    use_pp = ctl.pp && pp_allowed(ctl.idx) && (req_kind == K_SEND);
    hc_n   = use_pp ? CW'(pp_half(h_od)) : CW'(h_od);
  end

  assign hlen      = hc_q + CW'(str_q);
  assign low_last  = (st == PH_LOW)  && (cnt == hc_q - CW'(1));
  assign high_last = (st == PH_HIGH) && (cnt == hlen - CW'(1));
  assign sample_pt = (st == PH_HIGH) && (cnt == (hlen >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      cnt     <= '0;
      hc_q    <= '0;
      str_q   <= '0;
      kind_q  <= K_SEND;
      bit_q   <= 1'b0;
      pp_q    <= 1'b0;
      bus_q   <= '0;
      sda_drv <= 1'b0;
      sda_lvl <= 1'b1;
      done_q  <= 1'b0;
      samp_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        PH_IDLE: begin
          if (accept) begin
            st     <= PH_LOW;
            cnt    <= '0;
            hc_q   <= hc_n;
            str_q  <= stretch;
            kind_q <= req_kind;
            bit_q  <= req_bit;
            pp_q   <= use_pp;
            bus_q  <= ctl.bus;
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            // SCL already low for one cycle: safe to move SDA
            sda_drv <= (kind_q == K_SEND);
            sda_lvl <= bit_q;
          end
          if (low_last) begin
            st  <= PH_HIGH;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_HIGH: begin
          if (sample_pt) samp_q <= sda_rx;
          if (high_last) begin
            st     <= PH_IDLE;
            cnt    <= '0;
            pp_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign idle     = (st == PH_IDLE);
  assign done     = done_q;
  assign done_bit = samp_q;
  assign scl_lvl  = (st != PH_LOW);
  assign pp_act   = pp_q;

  p_pp_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (ctl.idx >= 4'd14) |=> !pp_q);

  p_recv_od_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pp_q |-> (kind_q == K_SEND));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PH_IDLE) |=> ($stable(kind_q) && $stable(bit_q) && $stable(hc_q)));

  p_done_after_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(st) == PH_HIGH));

  p_low_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_LOW) |-> (cnt < hc_q));

endmodule

// File: rtl/sclgen_pads.sv
module sclgen_pads #(
  parameter int unsigned BUS_W = 2,
  localparam int unsigned NPAIR = 1 << BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_q,
  input  logic             scl_lvl,
  input  logic             sda_drv,
  input  logic             sda_lvl,
  input  logic             pp_act,
  input  logic [NPAIR-1:0] sda_in,
  output logic [NPAIR-1:0] scl_oe,
  output logic [NPAIR-1:0] scl_hi,
  output logic [NPAIR-1:0] sda_oe,
  output logic [NPAIR-1:0] sda_hi,
  output logic             sda_rx
);

  logic [NPAIR-1:0] pair_act;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic sel;
    logic drv_en;
    assign sel         = (bus_q == BUS_W'(i));
    assign drv_en      = sel && sda_drv;
    assign scl_oe[i]   = sel && (pp_act || !scl_lvl);
    assign scl_hi[i]   = sel && pp_act && scl_lvl;
    assign sda_oe[i]   = drv_en && (pp_act || !sda_lvl);
    assign sda_hi[i]   = drv_en && pp_act && sda_lvl;
    assign pair_act[i] = scl_oe[i] | scl_hi[i] | sda_oe[i] | sda_hi[i];
  end

  assign sda_rx = sda_in[bus_q];

  p_one_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_act));

  p_od_nohi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pp_act |-> ((scl_hi == '0) && (sda_hi == '0)));

endmodule

// File: rtl/i2c_scl_phy.sv
module i2c_scl_phy
  import sclgen_pkg::*;
#(
  parameter int unsigned STD_UNIT  = 4,
  parameter int unsigned FAST_UNIT = 2,
  parameter int unsigned STW       = 4,
  localparam int unsigned BUS_W = 2,
  localparam int unsigned NPAIR = 1 << BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_data,
  input  logic [STW-1:0]   stretch,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_bit,
  output logic             idle,
  output logic             done,
  output logic             done_bit,
  output logic [NPAIR-1:0] scl_oe,
  output logic [NPAIR-1:0] scl_hi,
  output logic [NPAIR-1:0] sda_oe,
  output logic [NPAIR-1:0] sda_hi,
  input  logic [NPAIR-1:0] sda_in
);

  ctl_t             ctl;
  logic             scl_lvl;
  logic             sda_drv;
  logic             sda_lvl;
  logic             pp_act;
  logic             sda_rx;
  logic [BUS_W-1:0] bus_q;
  logic             sda_line;

  sclgen_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_data),
    .ctl   (ctl)
  );

  sclgen_phase #(
    .STD_UNIT  (STD_UNIT),
    .FAST_UNIT (FAST_UNIT),
    .STW       (STW),
    .BUS_W     (BUS_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .stretch   (stretch),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_bit   (req_bit),
    .sda_rx    (sda_rx),
    .idle      (idle),
    .done      (done),
    .done_bit  (done_bit),
    .scl_lvl   (scl_lvl),
    .sda_drv   (sda_drv),
    .sda_lvl   (sda_lvl),
    .pp_act    (pp_act),
    .bus_q     (bus_q)
  );

  sclgen_pads #(.BUS_W(BUS_W)) u_pads (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_q   (bus_q),
    .scl_lvl (scl_lvl),
    .sda_drv (sda_drv),
    .sda_lvl (sda_lvl),
    .pp_act  (pp_act),
    .sda_in  (sda_in),
    .scl_oe  (scl_oe),
    .scl_hi  (scl_hi),
    .sda_oe  (sda_oe),
    .sda_hi  (sda_hi),
    .sda_rx  (sda_rx)
  );

  // logical SDA level on the selected pair
  assign sda_line = sda_drv ? sda_lvl : 1'b1;

  p_sda_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_lvl) && scl_lvl) |-> $stable(sda_line));

endmodule

// File: tb/tb_i2c_scl_phy.sv
module tb_i2c_scl_phy;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic [3:0] stretch = '0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic       req_bit = 1'b0;
  logic       idle, done, done_bit;
  logic [3:0] scl_oe, scl_hi, sda_oe, sda_hi;
  logic [3:0] sda_in = 4'hF;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_scl_phy dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .stretch(stretch), .req_valid(req_valid), .req_kind(req_kind),
    .req_bit(req_bit), .idle(idle), .done(done), .done_bit(done_bit),
    .scl_oe(scl_oe), .scl_hi(scl_hi), .sda_oe(sda_oe), .sda_hi(sda_hi),
    .sda_in(sda_in)
  );

  // {cfg, kind, bit, stretch, exp_low, exp_high, exp_pp}
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 2'd0, 1'b1, 4'd0, 8'd64, 8'd64, 1'b0},
    {8'h4A, 2'd0, 1'b0, 4'd0, 8'd24, 8'd24, 1'b0},
    {8'hB5, 2'd0, 1'b1, 4'd0, 8'd11, 8'd11, 1'b1},
    {8'hB5, 2'd1, 1'b0, 4'd3, 8'd22, 8'd25, 1'b0},
    {8'hFE, 2'd0, 1'b0, 4'd0, 8'd4,  8'd4,  1'b0},
    {8'hFF, 2'd0, 1'b1, 4'd2, 8'd2,  8'd4,  1'b0},
    {8'h3D, 2'd0, 1'b0, 4'd1, 8'd3,  8'd4,  1'b1},
    {8'h3D, 2'd2, 1'b0, 4'd0, 8'd6,  8'd6,  1'b0},
    {8'h1F, 2'd0, 1'b1, 4'd0, 8'd4,  8'd4,  1'b0},
    {8'h1C, 2'd0, 1'b1, 4'd0, 8'd8,  8'd8,  1'b1},
    {8'h7F, 2'd1, 1'b0, 4'd0, 8'd2,  8'd2,  1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic line(input logic oe, input logic hi);
    return oe ? hi : 1'b1;
  endfunction

  task automatic run_bit(input logic do_wr, input logic [7:0] cfg, input logic [1:0] kind,
                         input logic b, input logic [3:0] str, input int elow,
                         input int ehigh, input logic epp, input logic want,
                         input logic poke);
    int nlow = 0;
    int nhigh = 0;
    int e_other = 0;
    int e_mode = 0;
    int e_sda = 0;
    int e_stab = 0;
    logic seen = 1'b0;
    logic pscl = 1'b0;
    logic psda = 1'b1;
    logic first = 1'b1;
    int bsel = int'(cfg[7:6]);
    if (do_wr) begin
      cfg_data = cfg; cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0;
    end
    stretch = str; req_kind = kind; req_bit = b; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk(idle == 1'b0, "R10 busy", int'(idle), 0);
    for (int it = 0; it < 400; it++) begin
      logic s, d;
      if (done) begin seen = 1'b1; break; end
      s = line(scl_oe[bsel], scl_hi[bsel]);
      d = line(sda_oe[bsel], sda_hi[bsel]);
      for (int j = 0; j < 4; j++)
        if (j != bsel && (scl_oe[j] | scl_hi[j] | sda_oe[j] | sda_hi[j])) e_other++;
      if (epp && !scl_oe[bsel]) e_mode++;
      if (!epp && (scl_hi[bsel] || sda_hi[bsel])) e_mode++;
      if (!first && pscl && s && (d != psda)) e_stab++;
      req_valid = 1'b0;
      if (!s) begin
        if (poke && nlow == 3) begin req_valid = 1'b1; req_kind = 2'd1; end
        nlow++;
      end else begin
        if (kind == 2'd0) begin
          if (epp && !(sda_oe[bsel] && sda_hi[bsel] == b)) e_sda++;
          if (!epp && !(sda_oe[bsel] == !b)) e_sda++;
        end else if (sda_oe[bsel] || sda_hi[bsel]) e_sda++;
        sda_in[bsel] = (nhigh == ehigh / 2) ? want : ~want;
        nhigh++;
      end
      pscl = s; psda = d; first = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(seen, "R11 done seen", int'(seen), 1);
    chk(nlow == elow, "R3/R4 low length", nlow, elow);
    chk(nhigh == ehigh, "R3/R9 high length", nhigh, ehigh);
    chk(done_bit == want, "R11 sample point", int'(done_bit), int'(want));
    chk(e_other == 0, "R2 other pairs quiet", e_other, 0);
    chk(e_mode == 0, "R4/R5/R7 scl drive mode", e_mode, 0);
    chk(e_sda == 0, "R4/R6/R7 sda drive", e_sda, 0);
    chk(e_stab == 0, "R8 sda stable while scl high", e_stab, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 single pulse", int'(done), 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        chk(idle && !done && line(scl_oe[bsel], scl_hi[bsel]),
            "R10 no extra bit", int'(idle), 1);
        @(negedge clk);
      end
    end
    sda_in = 4'hF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(idle == 1'b1 && done == 1'b0, "R1 reset status", int'({idle, done}), 2);
    chk({scl_oe, scl_hi, sda_oe, sda_hi} == '0, "R1 reset drives",
        int'({scl_oe, scl_hi, sda_oe, sda_hi}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({scl_oe, scl_hi, sda_oe, sda_hi} == '0, "R1 after release",
        int'({scl_oe, scl_hi, sda_oe, sda_hi}), 0);
    // R1: default control byte 00h without a write: bus 0, standard, H=64
    run_bit(1'b0, 8'h00, 2'd1, 1'b0, 4'd0, 64, 64, 1'b0, 1'b1, 1'b0);
    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      run_bit(1'b1, v[31:24], v[23:22], v[21], v[20:17], int'(v[16:9]),
              int'(v[8:1]), v[0], logic'(i % 2), 1'b0);
    end
    // R10: request during a running bit is ignored
    run_bit(1'b1, 8'h4A, 2'd0, 1'b1, 4'd0, 24, 24, 1'b0, 1'b0, 1'b1);
    // R4 then R6 back to back on the same pair with push-pull enabled
    run_bit(1'b1, 8'h9C, 2'd0, 1'b0, 4'd0, 8, 8, 1'b1, 1'b1, 1'b0);
    run_bit(1'b0, 8'h9C, 2'd2, 1'b0, 4'd5, 16, 21, 1'b0, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule